// File: doc/BRIEF.md
# Banked UART Register File

This block holds the byte-wide control and status registers of an enhanced 16550-style UART behind a small address window. Several registers share one offset, and the register that an access reaches is chosen by the current line-control value, by an enhanced-enable bit in the feature register and by a window-select bit in the modem-control register. The block decodes each read and write and applies write protection to the enhanced fields. It returns live status taken from the datapath: receive data, FIFO flags, modem lines, autobaud result and interrupt sources.

Writes take effect at the rising clock edge while `wr_en` is high. Reads are combinational from `addr`. `rhr_pop` and `thr_push` flag the accesses that move data through the receive and transmit paths. The configuration outputs give the datapath the current register contents.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the line-control register holds LCR_RST (default 0x00). IER, MCR, FCR, EFR, TCR and TLR hold 0x00, and offset 2 in the normal bank reads 0x01.
- R2: While LCR equals 0xBF, offset 2 reads and writes EFR. Offsets 4, 5, 6 and 7 reach XON1, XON2, XOFF1 and XOFF2, and offsets 0 and 1 reach the divisor low and high bytes.
- R3: While LCR bit 7 is set and LCR is not 0xBF, offsets 0 and 1 reach the divisor and offset 2 reads the autobaud status input. Writes to offset 2 change no register. Offsets 4 to 7 behave as in the normal bank.
- R4: While LCR bit 7 is clear, a read of offset 0 returns `rhr_data` and raises `rhr_pop`, and a write to offset 0 raises `thr_push`. A write to offset 2 loads FCR and leaves the offset 2 read value unchanged.
- R5: Offsets 6 and 7 reach TCR and TLR only while EFR bit 4 and MCR bit 6 are both set and LCR bit 7 is clear. Otherwise offset 6 reads the modem status and offset 7 reaches the scratch register, whatever the state of MCR bit 6.
- R6: While EFR bit 4 is clear, writes leave IER bits 7:4 and MCR bits 7:5 at their previous values and update the lower bits.
- R7: While EFR bit 4 is set, IER and MCR take every written bit, so that 0x34 and 0x22 read back exactly.
- R8: Outside the 0xBF bank, offset 5 reads line status: bit 0 is `rx_avail`, bit 5 is `thr_empty`, bit 6 is `tx_idle` and every other bit is 0. Writes to offset 5 there change nothing.
- R9: Offset 6 outside the TCR window reads modem status as {`modem_in`, 4'b0000}, and writes to it change no register.
- R10: Offset SSR_ADDR (default 8) reads {7'b0, `tx_fifo_full`} in every bank. Offsets 9 to 15 read 0x00 and ignore writes.
- R11: In the normal bank, offset 2 reads the interrupt identity of `irq_src` masked by IER bits 3:0. Source bit 2 gives 0x06, bit 0 gives 0x04, bit 1 gives 0x02 and bit 3 gives 0x00, in that priority. With nothing pending it reads 0x01.
- R12: The configuration outputs show the current contents of LCR, IER, FCR, MCR, EFR, TCR, TLR, the divisor as {DLH, DLL} and the flow characters as {XOFF2, XOFF1, XON2, XON1}.
- R13: Offset 3 reads and writes LCR in every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, used only to generate pops |
| rdata | output | 8 | Read data, combinational |
| rhr_data | input | 8 | Head of the receive FIFO |
| irq_src | input | 4 | Raw interrupt sources |
| modem_in | input | 4 | Modem input lines |
| rx_avail | input | 1 | Receive data present |
| thr_empty | input | 1 | Transmit holding path empty |
| tx_idle | input | 1 | Transmitter and holding register empty |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| autobaud_stat | input | 8 | Autobaud detection result |
| rhr_pop | output | 1 | Receive byte consumed |
| thr_push | output | 1 | Transmit byte written |
| lcr_o | output | 8 | Line control contents |
| ier_o | output | 8 | Interrupt enable contents |
| fcr_o | output | 8 | FIFO control contents |
| mcr_o | output | 8 | Modem control contents |
| efr_o | output | 8 | Enhanced feature contents |
| tcr_o | output | 8 | Flow threshold contents |
| tlr_o | output | 8 | Trigger level contents |
| div_o | output | 16 | Baud divisor |
| flow_o | output | 32 | Flow-control characters |

## Verification
The same offsets are exercised under four LCR values: 0x00, 0x1B, 0x80 and 0xBF. A read that returns the wrong register therefore shows up as a value from another bank. IER and MCR are written with all-ones-heavy patterns both with and without the enhanced bit, which separates the protected upper bits from the free lower bits. The TCR window is opened and then closed once by clearing MCR bit 6 and once by clearing EFR bit 4 with MCR bit 6 still set, so each gating term is tested alone. Interrupt sources are applied one at a time and then together to expose the priority order and the IER mask.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  localparam logic [7:0] ENH_KEY      = 8'hBF;
  localparam int         EFR_ENH_BIT  = 4;
  localparam int         MCR_WIN_BIT  = 6;

  // interrupt source bit positions in irq_src
  localparam int SRC_RXDATA = 0;
  localparam int SRC_THRE   = 1;
  localparam int SRC_LINE   = 2;
  localparam int SRC_MODEM  = 3;

  typedef enum logic [1:0] {BANK_NORM, BANK_DIV, BANK_ENH} bank_e;

  typedef enum logic [4:0] {
    RD_ZERO, RD_RHR, RD_IER, RD_IIR, RD_LCR, RD_MCR, RD_LSR, RD_MSR,
    RD_SPR, RD_DLL, RD_DLH, RD_UASR, RD_EFR, RD_XON1, RD_XON2,
    RD_XOFF1, RD_XOFF2, RD_TCR, RD_TLR, RD_SSR
  } rsrc_e;

  typedef struct packed {
    logic ier, fcr, lcr, mcr, spr, dll, dlh, efr;
    logic xon1, xon2, xoff1, xoff2, tcr, tlr;
  } wsel_t;

  typedef struct packed {
    logic [7:0] ier, lcr, mcr, spr, dll, dlh, efr;
    logic [7:0] xon1, xon2, xoff1, xoff2, tcr, tlr;
  } regs_t;

  function automatic bank_e bank_of(input logic [7:0] lcr);
    if (lcr == ENH_KEY) return BANK_ENH;
    if (lcr[7])         return BANK_DIV;
    return BANK_NORM;
  endfunction

  // protected bits keep the old value unless unlock is set
  function automatic logic [7:0] guard_merge(input logic [7:0] old_v,
                                             input logic [7:0] new_v,
                                             input logic [7:0] prot,
                                             input logic       unlock);
    if (unlock) return new_v;
    return (old_v & prot) | (new_v & ~prot);
  endfunction

  function automatic logic [7:0] iir_value(input logic [3:0] pend);
    if (pend[SRC_LINE])   return 8'h06;
    if (pend[SRC_RXDATA]) return 8'h04;
    if (pend[SRC_THRE])   return 8'h02;
    if (pend[SRC_MODEM])  return 8'h00;
    return 8'h01;
  endfunction

  function automatic logic [7:0] lsr_value(input logic rx_av,
                                           input logic thr_e,
                                           input logic idle);
    return {1'b0, idle, thr_e, 4'b0000, rx_av};
  endfunction

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SSR_ADDR = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        lcr,
  input  logic              enh_on,
  input  logic              win_sel,
  output bank_e             bank,
  output logic              tcr_win,
  output wsel_t             wsel,
  output rsrc_e             rsrc,
  output logic              rhr_pop,
  output logic              thr_push
);
  localparam int OFS_W = 3;

  logic [OFS_W-1:0] ofs;
  logic             in_base;
  wsel_t            wreq;
  logic             thr_req;

  assign bank    = bank_of(lcr);
  assign tcr_win = enh_on & win_sel & (bank == BANK_NORM);
  assign ofs     = addr[OFS_W-1:0];
  assign in_base = (addr >> OFS_W) == '0;

  always_comb begin
    wreq    = '0;
    thr_req = 1'b0;
    rsrc    = RD_ZERO;
    if (addr == ADDR_W'(SSR_ADDR)) begin
      rsrc = RD_SSR;
    end else if (in_base) begin
      unique case (ofs)
        3'd0: if (bank == BANK_NORM) begin rsrc = RD_RHR; thr_req = 1'b1; end
              else begin rsrc = RD_DLL; wreq.dll = 1'b1; end
        3'd1: if (bank == BANK_NORM) begin rsrc = RD_IER; wreq.ier = 1'b1; end
              else begin rsrc = RD_DLH; wreq.dlh = 1'b1; end
        3'd2: unique case (bank)
                BANK_NORM: begin rsrc = RD_IIR; wreq.fcr = 1'b1; end
                BANK_DIV:  rsrc = RD_UASR;
                default:   begin rsrc = RD_EFR; wreq.efr = 1'b1; end
              endcase
        3'd3: begin rsrc = RD_LCR; wreq.lcr = 1'b1; end
        3'd4: if (bank == BANK_ENH) begin rsrc = RD_XON1; wreq.xon1 = 1'b1; end
              else begin rsrc = RD_MCR; wreq.mcr = 1'b1; end
        3'd5: if (bank == BANK_ENH) begin rsrc = RD_XON2; wreq.xon2 = 1'b1; end
              else rsrc = RD_LSR;
        3'd6: if (bank == BANK_ENH) begin rsrc = RD_XOFF1; wreq.xoff1 = 1'b1; end
              else if (tcr_win) begin rsrc = RD_TCR; wreq.tcr = 1'b1; end
              else rsrc = RD_MSR;
        default: if (bank == BANK_ENH) begin rsrc = RD_XOFF2; wreq.xoff2 = 1'b1; end
              else if (tcr_win) begin rsrc = RD_TLR; wreq.tlr = 1'b1; end
              else begin rsrc = RD_SPR; wreq.spr = 1'b1; end
      endcase
    end
  end

  assign wsel     = wr_en ? wreq : '0;
  assign thr_push = wr_en & thr_req;
  assign rhr_pop  = rd_en & (rsrc == RD_RHR);

endmodule

// File: rtl/uart_bank_store.sv
module uart_bank_store
  import uart_bank_pkg::*;
#(
  parameter logic [7:0] LCR_RST  = 8'h00,
  parameter logic [7:0] IER_PROT = 8'hF0,
  parameter logic [7:0] MCR_PROT = 8'hE0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wsel_t      wsel,
  input  logic [7:0] wdata,
  output regs_t      q,
  output logic [7:0] fcr_q
);
  logic unlock;
  assign unlock = q.efr[EFR_ENH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      q.lcr <= LCR_RST;
      fcr_q <= '0;
    end else begin
      if (wsel.ier)   q.ier   <= guard_merge(q.ier, wdata, IER_PROT, unlock);
      if (wsel.mcr)   q.mcr   <= guard_merge(q.mcr, wdata, MCR_PROT, unlock);
      if (wsel.fcr)   fcr_q   <= wdata;
      if (wsel.lcr)   q.lcr   <= wdata;
      if (wsel.spr)   q.spr   <= wdata;
      if (wsel.dll)   q.dll   <= wdata;
      if (wsel.dlh)   q.dlh   <= wdata;
      if (wsel.efr)   q.efr   <= wdata;
      if (wsel.xon1)  q.xon1  <= wdata;
      if (wsel.xon2)  q.xon2  <= wdata;
      if (wsel.xoff1) q.xoff1 <= wdata;
      if (wsel.xoff2) q.xoff2 <= wdata;
      if (wsel.tcr)   q.tcr   <= wdata;
      if (wsel.tlr)   q.tlr   <= wdata;
    end
  end

endmodule

// File: rtl/uart_bank_rdmux.sv
module uart_bank_rdmux
  import uart_bank_pkg::*;
(
  input  rsrc_e      rsrc,
  input  regs_t      q,
  input  logic [7:0] rhr_data,
  input  logic [3:0] irq_src,
  input  logic [3:0] modem_in,
  input  logic       rx_avail,
  input  logic       thr_empty,
  input  logic       tx_idle,
  input  logic       tx_fifo_full,
  input  logic [7:0] autobaud_stat,
  output logic [7:0] rdata
);
  logic [3:0] pend;
  assign pend = irq_src & q.ier[3:0];

  always_comb begin
    unique case (rsrc)
      RD_RHR:   rdata = rhr_data;
      RD_IER:   rdata = q.ier;
      RD_IIR:   rdata = iir_value(pend);
      RD_LCR:   rdata = q.lcr;
      RD_MCR:   rdata = q.mcr;
      RD_LSR:   rdata = lsr_value(rx_avail, thr_empty, tx_idle);
      RD_MSR:   rdata = {modem_in, 4'b0000};
      RD_SPR:   rdata = q.spr;
      RD_DLL:   rdata = q.dll;
      RD_DLH:   rdata = q.dlh;
      RD_UASR:  rdata = autobaud_stat;
      RD_EFR:   rdata = q.efr;
      RD_XON1:  rdata = q.xon1;
      RD_XON2:  rdata = q.xon2;
      RD_XOFF1: rdata = q.xoff1;
      RD_XOFF2: rdata = q.xoff2;
      RD_TCR:   rdata = q.tcr;
      RD_TLR:   rdata = q.tlr;
      RD_SSR:   rdata = {7'b0, tx_fifo_full};
      default:  rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         SSR_ADDR = 8,
  parameter logic [7:0] LCR_RST  = 8'h00,
  parameter logic [7:0] IER_PROT = 8'hF0,
  parameter logic [7:0] MCR_PROT = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic [7:0]        rhr_data,
  input  logic [3:0]        irq_src,
  input  logic [3:0]        modem_in,
  input  logic              rx_avail,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              tx_fifo_full,
  input  logic [7:0]        autobaud_stat,
  output logic              rhr_pop,
  output logic              thr_push,
  output logic [7:0]        lcr_o,
  output logic [7:0]        ier_o,
  output logic [7:0]        fcr_o,
  output logic [7:0]        mcr_o,
  output logic [7:0]        efr_o,
  output logic [7:0]        tcr_o,
  output logic [7:0]        tlr_o,
  output logic [15:0]       div_o,
  output logic [31:0]       flow_o
);
  // named internal events, observed by the bound checker
  bank_e bank;
  logic  tcr_win;
  wsel_t wsel;
  rsrc_e rsrc;
  regs_t q;

  uart_bank_decode #(.ADDR_W(ADDR_W), .SSR_ADDR(SSR_ADDR)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .lcr     (q.lcr),
    .enh_on  (q.efr[EFR_ENH_BIT]),
    .win_sel (q.mcr[MCR_WIN_BIT]),
    .bank    (bank),
    .tcr_win (tcr_win),
    .wsel    (wsel),
    .rsrc    (rsrc),
    .rhr_pop (rhr_pop),
    .thr_push(thr_push)
  );

  uart_bank_store #(.LCR_RST(LCR_RST), .IER_PROT(IER_PROT), .MCR_PROT(MCR_PROT)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wsel (wsel),
    .wdata(wdata),
    .q    (q),
    .fcr_q(fcr_o)
  );

  uart_bank_rdmux u_rd (
    .rsrc         (rsrc),
    .q            (q),
    .rhr_data     (rhr_data),
    .irq_src      (irq_src),
    .modem_in     (modem_in),
    .rx_avail     (rx_avail),
    .thr_empty    (thr_empty),
    .tx_idle      (tx_idle),
    .tx_fifo_full (tx_fifo_full),
    .autobaud_stat(autobaud_stat),
    .rdata        (rdata)
  );

  assign lcr_o  = q.lcr;
  assign ier_o  = q.ier;
  assign mcr_o  = q.mcr;
  assign efr_o  = q.efr;
  assign tcr_o  = q.tcr;
  assign tlr_o  = q.tlr;
  assign div_o  = {q.dlh, q.dll};
  assign flow_o = {q.xoff2, q.xoff1, q.xon2, q.xon1};

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk
  import uart_bank_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         SSR_ADDR = 8,
  parameter logic [7:0] LCR_RST  = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [3:0]        irq_src,
  input logic              tx_fifo_full,
  input logic              rhr_pop,
  input logic [7:0]        lcr_o,
  input logic [7:0]        ier_o,
  input logic [7:0]        mcr_o,
  input logic [7:0]        efr_o,
  input wsel_t             wsel,
  input rsrc_e             rsrc
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_lcr_R1: assert (lcr_o == LCR_RST && efr_o == 8'h00);
    end
  end

  assert_efr_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.efr |-> lcr_o == ENH_KEY);

  assert_rhr_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_pop |-> (rd_en && addr == '0 && !lcr_o[7]));

  assert_tcr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[EFR_ENH_BIT] |-> !(wsel.tcr || wsel.tlr || rsrc == RD_TCR || rsrc == RD_TLR));

  assert_ier_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1) && !lcr_o[7] && !efr_o[EFR_ENH_BIT]) |=> $stable(ier_o[7:4]));

  assert_mcr_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && lcr_o != ENH_KEY && !efr_o[EFR_ENH_BIT]) |=> $stable(mcr_o[7:5]));

  assert_lsr_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(5) && lcr_o != ENH_KEY) |-> (rdata[7] == 1'b0 && rdata[4:1] == 4'b0000));

  assert_ssr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(SSR_ADDR)) |-> rdata == {7'b0, tx_fifo_full});

  assert_idle_iir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(2) && !lcr_o[7] && (irq_src & ier_o[3:0]) == 4'b0000) |-> rdata == 8'h01);

  assert_single_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));

endmodule

bind uart_bank_regs uart_bank_regs_chk #(
  .ADDR_W(ADDR_W), .SSR_ADDR(SSR_ADDR), .LCR_RST(LCR_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .irq_src(irq_src), .tx_fifo_full(tx_fifo_full),
  .rhr_pop(rhr_pop), .lcr_o(lcr_o), .ier_o(ier_o), .mcr_o(mcr_o),
  .efr_o(efr_o), .wsel(wsel), .rsrc(rsrc)
);

// File: tb/test_uart_bank_regs.sv
module test_uart_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata, rhr_data = '0, autobaud_stat = '0;
  logic [3:0] irq_src = '0, modem_in = '0;
  logic rx_avail = 1'b0, thr_empty = 1'b0, tx_idle = 1'b0, tx_fifo_full = 1'b0;
  logic rhr_pop, thr_push;
  logic [7:0] lcr_o, ier_o, fcr_o, mcr_o, efr_o, tcr_o, tlr_o;
  logic [15:0] div_o;
  logic [31:0] flow_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rd_val;
  logic rd_pop, wr_push;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bank_regs i_uart_bank_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rhr_data(rhr_data), .irq_src(irq_src),
    .modem_in(modem_in), .rx_avail(rx_avail), .thr_empty(thr_empty),
    .tx_idle(tx_idle), .tx_fifo_full(tx_fifo_full), .autobaud_stat(autobaud_stat),
    .rhr_pop(rhr_pop), .thr_push(thr_push), .lcr_o(lcr_o), .ier_o(ier_o),
    .fcr_o(fcr_o), .mcr_o(mcr_o), .efr_o(efr_o), .tcr_o(tcr_o), .tlr_o(tlr_o),
    .div_o(div_o), .flow_o(flow_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1 wr_push = thr_push;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 rd_val = rdata; rd_pop = rhr_pop;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    rd(a);
    chk(tag, {24'b0, rd_val}, {24'b0, exp});
  endtask

  task automatic set_enh(input logic [7:0] efr_v);
    wr(3, 8'hBF); wr(2, efr_v); wr(3, 8'h00);
  endtask

  task automatic t_reset;
    rd_chk("R1 lcr", 3, 8'h00);
    rd_chk("R1 ier", 1, 8'h00);
    rd_chk("R1 mcr", 4, 8'h00);
    rd_chk("R1 iir", 2, 8'h01);
    chk("R1 efr/tcr/tlr/fcr", {efr_o, tcr_o, tlr_o, fcr_o}, 32'h0);
  endtask

  task automatic t_lcr;
    wr(3, 8'h1B);
    rd_chk("R13 lcr rw", 3, 8'h1B);
    chk("R12 lcr_o", {24'b0, lcr_o}, 32'h1B);
    wr(3, 8'h00);
  endtask

  task automatic t_protect;
    wr(1, 8'hF5);
    rd_chk("R6 ier locked", 1, 8'h05);
    wr(4, 8'hFF);
    rd_chk("R6 mcr locked", 4, 8'h1F);
    chk("R12 mcr_o", {24'b0, mcr_o}, 32'h1F);
    wr(4, 8'h00);
  endtask

  task automatic t_enhanced;
    wr(3, 8'hBF);
    wr(2, 8'h10);
    rd_chk("R2 efr", 2, 8'h10);
    chk("R12 efr_o", {24'b0, efr_o}, 32'h10);
    wr(4, 8'h11); wr(5, 8'h22); wr(6, 8'h33); wr(7, 8'h44);
    rd_chk("R2 xon1", 4, 8'h11);
    rd_chk("R2 xon2", 5, 8'h22);
    rd_chk("R2 xoff1", 6, 8'h33);
    rd_chk("R2 xoff2", 7, 8'h44);
    chk("R12 flow_o", flow_o, 32'h44332211);
    wr(0, 8'h34); wr(1, 8'h12);
    rd_chk("R2 dll", 0, 8'h34);
    chk("R12 div_o", {16'b0, div_o}, 32'h1234);
    rd_chk("R13 lcr in enh bank", 3, 8'hBF);
    wr(3, 8'h00);
    wr(1, 8'h34);
    rd_chk("R7 ier", 1, 8'h34);
    wr(4, 8'h22);
    rd_chk("R7 mcr", 4, 8'h22);
    set_enh(8'h00);
    wr(1, 8'h0A);
    rd_chk("R6 ier upper held", 1, 8'h3A);
    wr(4, 8'h01);
    rd_chk("R6 mcr upper held", 4, 8'h21);
  endtask

  task automatic t_divisor;
    autobaud_stat = 8'h5C;
    wr(3, 8'h80);
    rd_chk("R3 uasr", 2, 8'h5C);
    wr(2, 8'hFF);
    chk("R3 write2 ignored", {16'b0, efr_o, fcr_o}, 32'h0);
    rd_chk("R3 dll", 0, 8'h34);
    rd_chk("R3 dlh", 1, 8'h12);
    rd_chk("R3 mcr", 4, 8'h21);
    wr(3, 8'h00);
  endtask

  task automatic t_data;
    rhr_data = 8'hA7;
    rd(0);
    chk("R4 rhr", {24'b0, rd_val}, 32'hA7);
    chk("R4 pop", {31'b0, rd_pop}, 32'h1);
    rd(1);
    chk("R4 no pop", {31'b0, rd_pop}, 32'h0);
    wr(0, 8'h5E);
    chk("R4 push", {31'b0, wr_push}, 32'h1);
    wr(2, 8'hC7);
    chk("R4 fcr", {24'b0, fcr_o}, 32'hC7);
    rd_chk("R4 iir unchanged", 2, 8'h01);
  endtask

  task automatic t_lsr;
    rx_avail = 1'b1; thr_empty = 1'b0; tx_idle = 1'b1;
    rd_chk("R8 lsr a", 5, 8'h41);
    rx_avail = 1'b0; thr_empty = 1'b1; tx_idle = 1'b0;
    rd_chk("R8 lsr b", 5, 8'h20);
    wr(5, 8'hFF);
    rd_chk("R8 lsr write ignored", 5, 8'h20);
  endtask

  task automatic t_msr;
    modem_in = 4'hA;
    rd_chk("R9 msr", 6, 8'hA0);
    wr(6, 8'hFF);
    chk("R9 msr write no tcr", {24'b0, tcr_o}, 32'h0);
    rd_chk("R9 msr after write", 6, 8'hA0);
    wr(7, 8'h5A);
    rd_chk("R5 spr", 7, 8'h5A);
  endtask

  task automatic t_window;
    set_enh(8'h10);
    wr(4, 8'h40);
    wr(6, 8'h44); wr(7, 8'h88);
    rd_chk("R5 tcr", 6, 8'h44);
    rd_chk("R5 tlr", 7, 8'h88);
    chk("R12 tcr/tlr", {16'b0, tcr_o, tlr_o}, 32'h4488);
    wr(4, 8'h00);
    rd_chk("R5 mcr6 clear msr", 6, 8'hA0);
    rd_chk("R5 mcr6 clear spr", 7, 8'h5A);
    wr(4, 8'h40);
    set_enh(8'h00);
    chk("R5 mcr6 still set", {31'b0, mcr_o[6]}, 32'h1);
    rd_chk("R5 efr4 clear msr", 6, 8'hA0);
    rd_chk("R5 efr4 clear spr", 7, 8'h5A);
  endtask

  task automatic t_ssr;
    tx_fifo_full = 1'b1;
    rd_chk("R10 ssr normal", 8, 8'h01);
    wr(3, 8'hBF);
    rd_chk("R10 ssr enh", 8, 8'h01);
    tx_fifo_full = 1'b0;
    rd_chk("R10 ssr clear", 8, 8'h00);
    wr(9, 8'hFF);
    rd_chk("R10 unused", 9, 8'h00);
    wr(3, 8'h00);
  endtask

  task automatic t_iir;
    wr(1, 8'h0F);
    irq_src = 4'b0101; rd_chk("R11 line first", 2, 8'h06);
    irq_src = 4'b0001; rd_chk("R11 rx", 2, 8'h04);
    irq_src = 4'b0010; rd_chk("R11 thre", 2, 8'h02);
    irq_src = 4'b1000; rd_chk("R11 modem", 2, 8'h00);
    irq_src = 4'b1111; rd_chk("R11 all", 2, 8'h06);
    wr(1, 8'h00);
    rd_chk("R11 masked", 2, 8'h01);
    irq_src = 4'b0000;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_lcr;
    t_protect;
    t_enhanced;
    t_divisor;
    t_data;
    t_lsr;
    t_msr;
    t_window;
    t_ssr;
    t_iir;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule